// File: doc/BRIEF.md
# Machine-Check Entry Controller

This block decides, once per clock, whether a 32-bit core enters its machine-check handler, enters a halted checkstop state, or does nothing. It watches an active-low external machine-check pin and a set of single-cycle error strobes from inside the core. When an entry is taken it captures the return address and the current machine state word, produces the rewritten state word the handler runs with, adds the sources to a syndrome register, optionally captures a faulting data address, and emits a one-clock redirect pulse with the handler fetch address.

When machine checks are disabled in the state word, a maskable machine check does not start the handler. It halts the core in a sticky checkstop instead. Some other faults that the core cannot survive do the same, and so does a second watchdog overflow configured for it. The core's pipeline uses the redirect pulse to flush and fetch from the vector. The checkstop flag holds the core halted until reset.

Top module: `mchk_entry`

## Requirements
- R1: An entry shows as `redirect_o` high for exactly one clock, starting one clock after the strobe is sampled. All saved outputs update on that same edge. Strobes that arrive together cause a single entry.
- R2: On entry `ret_addr_o` takes `cur_pc` and `ret_state_o` takes `cur_msr`, both unchanged.
- R3: On entry `msr_o` equals `cur_msr` with bits 26, 25, 18, 17, 15, 14, 13, 12, 11, 8, 5, 4 and 1 cleared (mask 0x0606F932). All other bits except bit 9 are kept.
- R4: The debug-enable bit 9 of `msr_o` is cleared when `dbg_en` is 0. When `dbg_en` is 1 it is cleared only if `dbg_de_clr` is 1; otherwise it keeps its value from `cur_msr`.
- R5: On entry `vector_o` = {`vec_base`[15:0], `vec_off`[11:0], 4'b0000}.
- R6: On entry the active sources are ORed into `syndrome_o`. The bits are: bit0 external pin, bit1 non-maskable request, bit2 cache parity, bit3 bus error, bit4 buffered-store bus error. Bits are never cleared except by reset.
- R7: `fault_addr_o` loads `par_addr` only on an entry that includes a cache parity error. Otherwise it holds its value.
- R8: The active-low `mchk_pin_n` passes through a synchronizer. Only its high-to-low transition counts as a source, and only while `pin_en` is 1. A level held low gives one entry.
- R9: When `cur_msr` bit 12 (machine-check enable) is 0, a maskable source (pin, parity, bus error, store bus error) sets `chkstop_o` and no entry occurs. `nmi_req` always causes an entry, whatever the value of bit 12.
- R10: When bit 12 is 0, `chkstop_o` is also set by `fetch_fault` or `store_bus_err`, and by `term_err` when `cur_msr` bit 15 (external enable) is 0. With bit 15 at 1, `term_err` has no effect.
- R11: `wd_second` with `wd_ctl` = 2'b01 sets `chkstop_o` whatever the value of bit 12. Any other `wd_ctl` value has no effect.
- R12: `chkstop_o` stays set until reset. While it is set, no further entry occurs and the syndrome does not change.
- R13: After reset every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cur_pc | input | 32 | Address of the current or next instruction |
| cur_msr | input | 32 | Current machine state word |
| vec_base | input | 16 | Upper half of the vector base register |
| vec_off | input | 12 | Machine-check offset field |
| pin_en | input | 1 | Enable for the external pin |
| mchk_pin_n | input | 1 | External machine-check pin, active low, asynchronous |
| dbg_en | input | 1 | Debug unit enabled |
| dbg_de_clr | input | 1 | Clear debug-enable on entry when the debug unit is on |
| nmi_req | input | 1 | Non-maskable machine-check strobe |
| par_err | input | 1 | Cache parity error on a data access |
| par_addr | input | 32 | Effective address of that access |
| bus_err | input | 1 | Bus error machine-check strobe |
| store_bus_err | input | 1 | Bus error on a buffered store |
| fetch_fault | input | 1 | First handler instruction could not be fetched |
| term_err | input | 1 | Precise external termination error |
| wd_second | input | 1 | Second watchdog overflow |
| wd_ctl | input | 2 | Watchdog reset-control field |
| redirect_o | output | 1 | One-clock handler redirect |
| vector_o | output | 32 | Handler fetch address |
| ret_addr_o | output | 32 | Saved return address |
| ret_state_o | output | 32 | Saved machine state word |
| msr_o | output | 32 | Rewritten machine state word |
| syndrome_o | output | 5 | Accumulated source bits |
| fault_addr_o | output | 32 | Captured data fault address |
| chkstop_o | output | 1 | Sticky checkstop |

## Verification
Two pairs of functions can fall in the same cycle. The first is the merging of several sources into one entry, provoked by raising parity, bus error and store bus error on one clock. It is judged by a single scoreboard item carrying all three syndrome bits, an empty queue on the next cycle, and the parity address captured. The second is a collision of a checkstop with an entry. A parity strobe is sent after checkstop is set, and a non-maskable request is sent with the enable bit clear. In the first case the bench checks that no redirect appears and the syndrome stays unchanged. In the second it checks that the entry is taken and no checkstop results.

// File: rtl/mchk_pkg.sv
package mchk_pkg;
    localparam int XLEN  = 32;
    localparam int SYN_W = 5;
    localparam int B_DE  = 9;
    localparam int B_ME  = 12;
    localparam int B_EE  = 15;
    localparam logic [XLEN-1:0] CLR_MASK = 32'h0606_F932;
    localparam logic [1:0] WD_STOP = 2'b01;
    localparam int SYN_PIN  = 0;
    localparam int SYN_NMI  = 1;
    localparam int SYN_PAR  = 2;
    localparam int SYN_BUS  = 3;
    localparam int SYN_SBUS = 4;

    typedef struct packed {
        logic             redirect;
        logic             stop;
        logic [XLEN-1:0]  ret_addr;
        logic [XLEN-1:0]  ret_state;
        logic [XLEN-1:0]  msr;
        logic [XLEN-1:0]  vector;
        logic [XLEN-1:0]  fault_addr;
        logic [SYN_W-1:0] syndrome;
    } entry_t;
endpackage

// File: rtl/mchk_pin_sync.sv
module mchk_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    input  logic enable,
    output logic fall_o
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '1;
                else        sync_q <= pin_n;
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '1;
                else        sync_q <= {sync_q[STAGES-2:0], pin_n};
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= sync_q[STAGES-1];
    end

    assign fall_o = enable & prev_q & ~sync_q[STAGES-1];
endmodule

// File: rtl/mchk_decide.sv
module mchk_decide
    import mchk_pkg::*;
(
    input  logic             stop_q,
    input  logic             me,
    input  logic             ee,
    input  logic [SYN_W-1:0] src,
    input  logic             fetch_fault,
    input  logic             term_err,
    input  logic             wd_second,
    input  logic [1:0]       wd_ctl,
    output logic             take,
    output logic             stop_now
);
    logic maskable;
    logic fatal_off;

    always_comb begin
        maskable  = src[SYN_PIN] | src[SYN_PAR] | src[SYN_BUS] | src[SYN_SBUS];
        fatal_off = maskable | fetch_fault | (term_err & ~ee);
        stop_now  = (~me & fatal_off) | (wd_second & (wd_ctl == WD_STOP));
        take      = ~stop_q & ~stop_now & (src[SYN_NMI] | (me & maskable));
    end
endmodule

// File: rtl/mchk_msr_edit.sv
module mchk_msr_edit
    import mchk_pkg::*;
(
    input  logic [XLEN-1:0] cur_msr,
    input  logic            dbg_en,
    input  logic            dbg_de_clr,
    input  logic [15:0]     vec_base,
    input  logic [11:0]     vec_off,
    output logic [XLEN-1:0] new_msr,
    output logic [XLEN-1:0] vector
);
    logic [XLEN-1:0] de_bit;

    always_comb begin
        de_bit  = '0;
        de_bit[B_DE] = ~dbg_en | dbg_de_clr;
        new_msr = cur_msr & ~CLR_MASK & ~de_bit;
        vector  = {vec_base, vec_off, 4'b0000};
    end
endmodule

// File: rtl/mchk_entry.sv
module mchk_entry
    import mchk_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [31:0]      cur_pc,
    input  logic [31:0]      cur_msr,
    input  logic [15:0]      vec_base,
    input  logic [11:0]      vec_off,
    input  logic             pin_en,
    input  logic             mchk_pin_n,
    input  logic             dbg_en,
    input  logic             dbg_de_clr,
    input  logic             nmi_req,
    input  logic             par_err,
    input  logic [31:0]      par_addr,
    input  logic             bus_err,
    input  logic             store_bus_err,
    input  logic             fetch_fault,
    input  logic             term_err,
    input  logic             wd_second,
    input  logic [1:0]       wd_ctl,
    output logic             redirect_o,
    output logic [31:0]      vector_o,
    output logic [31:0]      ret_addr_o,
    output logic [31:0]      ret_state_o,
    output logic [31:0]      msr_o,
    output logic [4:0]       syndrome_o,
    output logic [31:0]      fault_addr_o,
    output logic             chkstop_o
);
    entry_t st_d, st_q;
    logic   pin_fall;
    logic   take, stop_now;
    logic [SYN_W-1:0] src;
    logic [XLEN-1:0]  new_msr, vector;

    mchk_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_n  (mchk_pin_n),
        .enable (pin_en),
        .fall_o (pin_fall)
    );

    always_comb begin
        src           = '0;
        src[SYN_PIN]  = pin_fall;
        src[SYN_NMI]  = nmi_req;
        src[SYN_PAR]  = par_err;
        src[SYN_BUS]  = bus_err;
        src[SYN_SBUS] = store_bus_err;
    end

    mchk_decide u_decide (
        .stop_q      (st_q.stop),
        .me          (cur_msr[B_ME]),
        .ee          (cur_msr[B_EE]),
        .src         (src),
        .fetch_fault (fetch_fault),
        .term_err    (term_err),
        .wd_second   (wd_second),
        .wd_ctl      (wd_ctl),
        .take        (take),
        .stop_now    (stop_now)
    );

    mchk_msr_edit u_edit (
        .cur_msr    (cur_msr),
        .dbg_en     (dbg_en),
        .dbg_de_clr (dbg_de_clr),
        .vec_base   (vec_base),
        .vec_off    (vec_off),
        .new_msr    (new_msr),
        .vector     (vector)
    );

    always_comb begin
        st_d          = st_q;
        st_d.redirect = take;
        st_d.stop     = st_q.stop | stop_now;
        if (take) begin
            st_d.ret_addr  = cur_pc;
            st_d.ret_state = cur_msr;
            st_d.msr       = new_msr;
            st_d.vector    = vector;
            st_d.syndrome  = st_q.syndrome | src;
            if (par_err) st_d.fault_addr = par_addr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign redirect_o   = st_q.redirect;
    assign vector_o     = st_q.vector;
    assign ret_addr_o   = st_q.ret_addr;
    assign ret_state_o  = st_q.ret_state;
    assign msr_o        = st_q.msr;
    assign syndrome_o   = st_q.syndrome;
    assign fault_addr_o = st_q.fault_addr;
    assign chkstop_o    = st_q.stop;

    p_ret_state_r2: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_o |-> (ret_state_o == $past(cur_msr)) && (ret_addr_o == $past(cur_pc)));

    p_msr_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_o |-> ((msr_o & CLR_MASK) == '0) &&
        (((msr_o ^ $past(cur_msr)) & ~(CLR_MASK | (32'h1 << B_DE))) == '0));

    p_vec_align_r5: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_o |-> (vector_o[3:0] == 4'h0) && (vector_o[31:16] == $past(vec_base)));

    p_syn_grow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((syndrome_o & $past(syndrome_o)) == $past(syndrome_o)));

    p_fa_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_addr_o != $past(fault_addr_o)) |-> redirect_o);

    p_stop_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        chkstop_o |=> chkstop_o);

    p_stop_blocks_r12: assert property (@(posedge clk) disable iff (!rst_n)
        chkstop_o |-> !redirect_o);
endmodule

// File: tb/sim_mchk_entry.sv
module sim_mchk_entry;
    localparam int CLK_P = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [31:0] cur_pc = '0, cur_msr = '0, par_addr = '0;
    logic [15:0] vec_base = '0;
    logic [11:0] vec_off = '0;
    logic pin_en = 0, mchk_pin_n = 1, dbg_en = 0, dbg_de_clr = 0;
    logic nmi_req = 0, par_err = 0, bus_err = 0, store_bus_err = 0;
    logic fetch_fault = 0, term_err = 0, wd_second = 0;
    logic [1:0] wd_ctl = 2'b00;
    logic redirect_o, chkstop_o;
    logic [31:0] vector_o, ret_addr_o, ret_state_o, msr_o, fault_addr_o;
    logic [4:0] syndrome_o;

    mchk_entry u0 (.*);

    always #(CLK_P/2) clk = ~clk;

    typedef struct {
        logic [31:0] ra, rs, msr, vec, fa;
        logic [4:0]  syn;
    } exp_t;
    exp_t q[$];
    int checks = 0, errs = 0;
    logic [4:0]  syn_m = '0;
    logic [31:0] fa_m = '0;
    bit done = 0;

    task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic exp_t make_exp();
        exp_t e;
        logic [31:0] de;
        de = (!dbg_en || dbg_de_clr) ? 32'h0000_0200 : 32'h0;
        e.ra  = cur_pc;
        e.rs  = cur_msr;
        e.msr = cur_msr & ~32'h0606_F932 & ~de;
        e.vec = {vec_base, vec_off, 4'h0};
        e.fa  = fa_m;
        e.syn = syn_m;
        return e;
    endfunction

    // monitor: pops one expected item per redirect
    always @(negedge clk) begin
        exp_t e;
        if (rst_n && redirect_o) begin
            if (q.size() == 0) chk(0, "R12", "unexpected redirect", 1, 0);
            else begin
                e = q.pop_front();
                chk(ret_addr_o == e.ra, "R2", "ret_addr", ret_addr_o, e.ra);
                chk(ret_state_o == e.rs, "R2", "ret_state", ret_state_o, e.rs);
                chk(msr_o == e.msr, "R3", "new msr (R4 DE)", msr_o, e.msr);
                chk(vector_o == e.vec, "R5", "vector", vector_o, e.vec);
                chk(syndrome_o == e.syn, "R6", "syndrome", {27'b0, syndrome_o}, {27'b0, e.syn});
                chk(fault_addr_o == e.fa, "R7", "fault_addr", fault_addr_o, e.fa);
            end
        end
    end

    task automatic do_reset();
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        q.delete();
        syn_m = '0;
        fa_m = '0;
    endtask

    // one-cycle strobe; ent says whether an entry is expected
    task automatic strobe(bit n, bit p, bit b, bit s, bit ent);
        @(negedge clk);
        nmi_req = n; par_err = p; bus_err = b; store_bus_err = s;
        if (ent) begin
            syn_m = syn_m | {s, b, p, n, 1'b0};
            if (p) fa_m = par_addr;
            q.push_back(make_exp());
        end
        @(negedge clk);
        nmi_req = 0; par_err = 0; bus_err = 0; store_bus_err = 0;
    endtask

    task automatic pulse_other(bit ff, bit te, bit wd);
        @(negedge clk);
        fetch_fault = ff; term_err = te; wd_second = wd;
        @(negedge clk);
        fetch_fault = 0; term_err = 0; wd_second = 0;
    endtask

    task automatic drained(string req);
        @(negedge clk);
        chk(q.size() == 0, req, "entry count", q.size(), 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errs++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        logic [4:0] syn_keep;
        vec_base = 16'hABCD; vec_off = 12'h123;
        do_reset();
        @(negedge clk);
        // R13 reset values
        chk({redirect_o, chkstop_o, syndrome_o} == 0 && msr_o == 0 && vector_o == 0 &&
            fault_addr_o == 0 && ret_addr_o == 0, "R13", "reset state", {25'b0, redirect_o, chkstop_o, syndrome_o}, 0);

        // R1 R7: parity entry, ME set
        cur_pc = 32'h0000_4000; cur_msr = 32'hFFFF_FFFF; par_addr = 32'hDEAD_0040;
        strobe(0, 1, 0, 0, 1);
        chk(redirect_o == 1, "R1", "redirect in cycle after strobe", redirect_o, 1);
        drained("R1");
        chk(redirect_o == 0, "R1", "redirect one cycle", redirect_o, 0);

        // R4: debug off clears DE; R7: bus error keeps fault address
        cur_pc = 32'h0000_5004; cur_msr = 32'h1234_5A78 | 32'h0000_1200; par_addr = 32'h1111_1111;
        dbg_en = 0; strobe(0, 0, 1, 0, 1); drained("R4");
        chk(fault_addr_o == 32'hDEAD_0040, "R7", "fault_addr held", fault_addr_o, 32'hDEAD_0040);
        dbg_en = 1; dbg_de_clr = 0; strobe(0, 0, 1, 0, 1); drained("R4");
        chk(msr_o[9] == 1, "R4", "DE kept", {31'b0, msr_o[9]}, 1);
        dbg_de_clr = 1; vec_base = 16'h0F0F; vec_off = 12'hFFF;
        strobe(0, 0, 1, 0, 1); drained("R5");

        // R1 R6: three sources in one cycle give one entry
        cur_pc = 32'h8000_0010; par_addr = 32'h0BAD_F00D;
        do_reset();
        cur_msr = 32'h0000_1000;
        strobe(0, 1, 1, 1, 1);
        drained("R1");
        chk(syndrome_o == 5'b11100, "R6", "merged sources", {27'b0, syndrome_o}, 32'h1C);

        // R8: pin disabled is ignored, enabled gives one entry per fall
        syn_keep = syndrome_o;
        pin_en = 0;
        @(negedge clk); mchk_pin_n = 0;
        repeat (6) @(negedge clk); mchk_pin_n = 1;
        repeat (4) @(negedge clk);
        chk(syndrome_o == syn_keep, "R8", "pin masked", {27'b0, syndrome_o}, {27'b0, syn_keep});
        pin_en = 1; cur_pc = 32'h0000_7770;
        @(negedge clk);
        mchk_pin_n = 0;
        syn_m = syn_m | 5'b00001;
        q.push_back(make_exp());
        repeat (8) @(negedge clk);
        mchk_pin_n = 1;
        drained("R8");
        pin_en = 0;

        // R9: non-maskable entry with ME clear, no checkstop
        cur_msr = 32'h0000_0000;
        strobe(1, 0, 0, 0, 1); drained("R9");
        chk(chkstop_o == 0, "R9", "nmi no checkstop", {31'b0, chkstop_o}, 0);

        // R9 R12: maskable with ME clear -> checkstop, then sticky
        strobe(0, 0, 1, 0, 0);
        chk(chkstop_o == 1, "R9", "bus error ME=0 stops", {31'b0, chkstop_o}, 1);
        syn_keep = syndrome_o;
        cur_msr = 32'h0000_1000;
        strobe(1, 1, 0, 0, 0); drained("R12");
        chk(chkstop_o == 1 && syndrome_o == syn_keep, "R12", "sticky, syndrome frozen",
            {26'b0, chkstop_o, syndrome_o}, {26'b0, 1'b1, syn_keep});

        // R10: fetch fault with ME clear
        do_reset(); cur_msr = 32'h0;
        pulse_other(1, 0, 0);
        chk(chkstop_o == 1, "R10", "fetch fault stops", {31'b0, chkstop_o}, 1);
        // R10: termination error depends on EE
        do_reset(); cur_msr = 32'h0000_8000;
        pulse_other(0, 1, 0);
        chk(chkstop_o == 0, "R10", "term with EE=1 ignored", {31'b0, chkstop_o}, 0);
        cur_msr = 32'h0;
        pulse_other(0, 1, 0);
        chk(chkstop_o == 1, "R10", "term with EE=0 stops", {31'b0, chkstop_o}, 1);
        // R10: buffered store bus error with ME clear
        do_reset();
        strobe(0, 0, 0, 1, 0);
        chk(chkstop_o == 1, "R10", "store bus error stops", {31'b0, chkstop_o}, 1);

        // R11: watchdog second overflow
        do_reset(); cur_msr = 32'h0000_1000; wd_ctl = 2'b10;
        pulse_other(0, 0, 1);
        chk(chkstop_o == 0, "R11", "watchdog other ctl", {31'b0, chkstop_o}, 0);
        wd_ctl = 2'b01;
        pulse_other(0, 0, 1);
        chk(chkstop_o == 1, "R11", "watchdog stop with ME=1", {31'b0, chkstop_o}, 1);

        repeat (3) @(negedge clk);
        chk(q.size() == 0, "R1", "scoreboard empty", q.size(), 0);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule